// File: doc/BRIEF.md
# Amplifier Mode and Protection Controller

This block is the control state machine of a two-channel switching audio amplifier. It takes the chip's active-low reset and mute inputs, and it runs the amplifier through four phases: a quiet hold while reset is low, a start-up count after reset is released, a muted phase in which the modulators run but neither bridge switches, and a play phase. A soft-start delay sits between muted and play, and a stop delay sits between play and muted. At the reset release edge it reads two strap inputs and fixes the operating mode from them. The mode is stereo, mono (the left stream drives both bridges in parallel and the right modulator is stopped) or external-modulator mode (both internal bridges stay off and the two raw modulator bits are routed to two shared pins).

The block also owns fault handling. A persistent overcurrent indication forces the muted phase and sets a latched, active-low flag. Only a mute or reset pulse that ends while the overcurrent is gone clears that flag. Three thermal comparator bits give a warning flag and a shutdown flag. The shutdown flag disables the bridges. Both thermal flags clear when the restore comparator reports that the die has cooled, and playback then resumes by itself. All outputs are registered and are updated on the rising clock edge.

Top module: `amp_guard_ctrl`

## Requirements
- R1: While rst_n is sampled low, the next edge drives these outputs: mod_l_en, mod_r_en, drv_l_en, drv_r_en, drv_l_data, drv_r_data and share_b_oe to 0, and share_a_out, warn_n and shut_n to 1.
- R2: After the first edge that samples rst_n high, mod_l_en is 1 from that edge onward. Both drive enables stay 0 through the STARTUP_CYC start-up count, and they stay 0 for as long as mute_n is held low afterwards.
- R3: In the muted phase, the first edge that samples mute_n high starts the soft-start count. The drive enables rise exactly UNMUTE_DLY edges later. If mute_n is sampled low during the count, the block goes back to muted, and the next release starts a full count again.
- R4: In play, the first edge that samples mute_n low starts the stop count. The drive enables fall exactly MUTE_DLY edges later.
- R5: The mode is taken from the straps at the reset release edge. ext_strap=1 selects external mode whatever mono_strap is. mono_strap=1 with ext_strap=0 selects mono. Both at 0 selects stereo. A strap change after release has no effect on any output.
- R6: In mono mode, mod_r_en is 0, r_src_left is 1, and drv_r_data follows mod_l. In the other two modes, r_src_left is 0 and mod_r_en equals mod_l_en.
- R7: In stereo play, drv_l_data equals mod_l and drv_r_data equals mod_r, each one edge after the input is sampled.
- R8: In external mode, both drive enables stay 0 and share_b_oe is 1. share_a_out carries mod_l and share_b_out carries mod_r, one edge late. The fault inputs are ignored: warn_n and shut_n stay 1, and share_a_out never shows an overcurrent flag.
- R9: When oc_det is sampled high on two consecutive edges, the overcurrent latch sets. share_a_out (active-low overcurrent flag) goes to 0 and the bridges are forced off. A high level on oc_det for a single sample is ignored.
- R10: Once set, the overcurrent latch is cleared by a rising mute_n sample while oc_det is low, or by a reset pulse. A mute release while oc_det is still high leaves it set. After a clear, the soft-start count runs again.
- R11: Once th_warn has been seen, warn_n is 0 and the bridges keep switching. warn_n stays 0 after th_warn drops and returns to 1 only when th_cool is seen.
- R12: Once th_shut has been seen, shut_n is 0 and the bridges are off. When th_cool is seen, both thermal flags return to 1, and the drive enables rise again after the soft-start count with no action on mute_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| mute_n | input | 1 | Active-low mute, sampled on the clock |
| mono_strap | input | 1 | Mono mode strap, read at reset release |
| ext_strap | input | 1 | External-modulator mode strap, read at reset release |
| oc_det | input | 1 | Overcurrent comparator, high means overcurrent |
| th_warn | input | 1 | Die above the warning threshold |
| th_shut | input | 1 | Die above the shutdown threshold |
| th_cool | input | 1 | Die below the restore threshold |
| mod_l | input | 1 | Left modulator bit stream |
| mod_r | input | 1 | Right modulator bit stream |
| mod_l_en | output | 1 | Left modulator run enable |
| mod_r_en | output | 1 | Right modulator run enable |
| drv_l_en | output | 1 | Left bridge drive enable (0 = tristated) |
| drv_r_en | output | 1 | Right bridge drive enable (0 = tristated) |
| drv_l_data | output | 1 | Bit driving the left bridge |
| drv_r_data | output | 1 | Bit driving the right bridge |
| r_src_left | output | 1 | Right bridge is fed from the left stream |
| share_a_out | output | 1 | Active-low overcurrent flag, or mod_l in external mode |
| share_b_out | output | 1 | mod_r in external mode, else 0 |
| share_b_oe | output | 1 | Output enable of the second shared pin |
| warn_n | output | 1 | Active-low thermal warning flag |
| shut_n | output | 1 | Active-low thermal shutdown flag |

## Verification
The block does not synchronise rst_n, mute_n, the straps or oc_det, so the properties assume these change away from the rising edge. The stimulus only changes them on the falling edge. The thermal properties assume that th_cool is never high together with th_warn or th_shut. The stimulus always drops the hot comparators before it raises th_cool. The straps are held steady around each release edge, and they are changed only well after it, when the test checks that such a change is ignored.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_START,
    ST_MUTED,
    ST_UNMUTE,
    ST_PLAY,
    ST_STOP
  } seq_state_t;

  typedef enum logic [1:0] {
    MODE_STEREO,
    MODE_MONO,
    MODE_EXT
  } amp_mode_t;

  localparam int TH_BITS = 3;
  localparam int TH_WARN = 0;
  localparam int TH_SHUT = 1;
  localparam int TH_COOL = 2;

endpackage

// File: rtl/amp_sync.sv
module amp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/amp_fault.sv
module amp_fault import amp_guard_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int OC_FILT     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mute_n,
  input  logic ext_mode,
  input  logic oc_det,
  input  logic th_warn,
  input  logic th_shut,
  input  logic th_cool,
  output logic oc_lat,
  output logic warn_lat,
  output logic shut_lat
);

  logic [TH_BITS-1:0] th_raw;
  logic [TH_BITS-1:0] th_s;
  logic               oc_trip;
  logic               mute_prev;
  logic               mute_rel;

  assign th_raw[TH_WARN] = th_warn;
  assign th_raw[TH_SHUT] = th_shut;
  assign th_raw[TH_COOL] = th_cool;

  amp_sync #(.WIDTH(TH_BITS), .STAGES(SYNC_STAGES)) u_th_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (th_raw),
    .q    (th_s)
  );

  generate
    if (OC_FILT > 1) begin : g_oc_filt
      logic [OC_FILT-2:0] oc_sh;
      always_ff @(posedge clk) begin
        if (!rst_n) oc_sh <= '0;
        else        oc_sh <= (oc_sh << 1) | (OC_FILT-1)'(oc_det);
      end
      assign oc_trip = oc_det & (&oc_sh);
    end else begin : g_oc_raw
      assign oc_trip = oc_det;
    end
  endgenerate

  assign mute_rel = mute_n & ~mute_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mute_prev <= 1'b0;
      oc_lat    <= 1'b0;
      warn_lat  <= 1'b0;
      shut_lat  <= 1'b0;
    end else begin
      mute_prev <= mute_n;
      if (oc_trip && !ext_mode)     oc_lat <= 1'b1;
      else if (mute_rel && !oc_det) oc_lat <= 1'b0;
      if (th_s[TH_WARN])            warn_lat <= 1'b1;
      else if (th_s[TH_COOL])       warn_lat <= 1'b0;
      if (th_s[TH_SHUT])            shut_lat <= 1'b1;
      else if (th_s[TH_COOL])       shut_lat <= 1'b0;
    end
  end

  AST_OC_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_lat) |-> ($past(oc_det) && $past(oc_det, 2))); // R9

  AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_lat && !th_s[TH_COOL]) |=> warn_lat); // R11

endmodule

// File: rtl/amp_seq.sv
module amp_seq import amp_guard_pkg::*; #(
  parameter int STARTUP_CYC = 256,
  parameter int UNMUTE_DLY  = 418,
  parameter int MUTE_DLY    = 123
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mute_n,
  input  logic       mono_strap,
  input  logic       ext_strap,
  input  logic       oc_lat,
  input  logic       shut_lat,
  output seq_state_t st_nxt,
  output amp_mode_t  mode_q
);

  localparam int MAX_A = (STARTUP_CYC > UNMUTE_DLY) ? STARTUP_CYC : UNMUTE_DLY;
  localparam int MAX_C = (MAX_A > MUTE_DLY) ? MAX_A : MUTE_DLY;
  localparam int CW    = $clog2(MAX_C + 1);

  seq_state_t     st_q;
  logic [CW-1:0]  cnt_q;
  logic           halt;

  assign halt = oc_lat | shut_lat;

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_HOLD:   st_nxt = ST_START;
      ST_START:  if (cnt_q == CW'(STARTUP_CYC - 1)) st_nxt = ST_MUTED;
      ST_MUTED:  if (mute_n && !halt) st_nxt = ST_UNMUTE;
      ST_UNMUTE: begin
        if (halt || !mute_n)                      st_nxt = ST_MUTED;
        else if (cnt_q == CW'(UNMUTE_DLY - 1))    st_nxt = ST_PLAY;
      end
      ST_PLAY: begin
        if (halt)         st_nxt = ST_MUTED;
        else if (!mute_n) st_nxt = ST_STOP;
      end
      ST_STOP: begin
        if (halt || cnt_q == CW'(MUTE_DLY - 1)) st_nxt = ST_MUTED;
      end
      default:   st_nxt = ST_HOLD;
    endcase
    if (!rst_n) st_nxt = ST_HOLD;
  end

  always_ff @(posedge clk) begin
    st_q <= st_nxt;
    if (st_nxt != st_q)
      cnt_q <= '0;
    else if (st_q == ST_START || st_q == ST_UNMUTE || st_q == ST_STOP)
      cnt_q <= cnt_q + 1'b1;
    if (!rst_n)
      mode_q <= MODE_STEREO;
    else if (st_q == ST_HOLD)
      mode_q <= ext_strap ? MODE_EXT : (mono_strap ? MODE_MONO : MODE_STEREO);
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_HOLD && $past(st_q != ST_HOLD)) |-> $stable(mode_q)); // R5

  AST_REMUTE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_UNMUTE && !mute_n) |=> st_q == ST_MUTED); // R3

endmodule

// File: rtl/amp_guard_ctrl.sv
module amp_guard_ctrl import amp_guard_pkg::*; #(
  parameter int STARTUP_CYC = 256,
  parameter int UNMUTE_DLY  = 418,
  parameter int MUTE_DLY    = 123,
  parameter int SYNC_STAGES = 2,
  parameter int OC_FILT     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mute_n,
  input  logic mono_strap,
  input  logic ext_strap,
  input  logic oc_det,
  input  logic th_warn,
  input  logic th_shut,
  input  logic th_cool,
  input  logic mod_l,
  input  logic mod_r,
  output logic mod_l_en,
  output logic mod_r_en,
  output logic drv_l_en,
  output logic drv_r_en,
  output logic drv_l_data,
  output logic drv_r_data,
  output logic r_src_left,
  output logic share_a_out,
  output logic share_b_out,
  output logic share_b_oe,
  output logic warn_n,
  output logic shut_n
);

  seq_state_t st_nxt;
  amp_mode_t  mode_q;
  logic       oc_lat;
  logic       warn_lat;
  logic       shut_lat;
  logic       is_ext;
  logic       is_mono;
  logic       drive;

  amp_fault #(.SYNC_STAGES(SYNC_STAGES), .OC_FILT(OC_FILT)) u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .mute_n  (mute_n),
    .ext_mode(is_ext),
    .oc_det  (oc_det),
    .th_warn (th_warn),
    .th_shut (th_shut),
    .th_cool (th_cool),
    .oc_lat  (oc_lat),
    .warn_lat(warn_lat),
    .shut_lat(shut_lat)
  );

  amp_seq #(.STARTUP_CYC(STARTUP_CYC), .UNMUTE_DLY(UNMUTE_DLY), .MUTE_DLY(MUTE_DLY)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mute_n    (mute_n),
    .mono_strap(mono_strap),
    .ext_strap (ext_strap),
    .oc_lat    (oc_lat),
    .shut_lat  (shut_lat),
    .st_nxt    (st_nxt),
    .mode_q    (mode_q)
  );

  assign is_ext  = (mode_q == MODE_EXT);
  assign is_mono = (mode_q == MODE_MONO);
  assign drive   = (st_nxt == ST_PLAY || st_nxt == ST_STOP) && !is_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_l_en    <= 1'b0;
      mod_r_en    <= 1'b0;
      drv_l_en    <= 1'b0;
      drv_r_en    <= 1'b0;
      drv_l_data  <= 1'b0;
      drv_r_data  <= 1'b0;
      r_src_left  <= 1'b0;
      share_a_out <= 1'b1;
      share_b_out <= 1'b0;
      share_b_oe  <= 1'b0;
      warn_n      <= 1'b1;
      shut_n      <= 1'b1;
    end else begin
      mod_l_en    <= (st_nxt != ST_HOLD);
      mod_r_en    <= (st_nxt != ST_HOLD) && !is_mono;
      drv_l_en    <= drive;
      drv_r_en    <= drive;
      drv_l_data  <= drive & mod_l;
      drv_r_data  <= drive & (is_mono ? mod_l : mod_r);
      r_src_left  <= is_mono;
      share_a_out <= is_ext ? mod_l : ~oc_lat;
      share_b_out <= is_ext & mod_r;
      share_b_oe  <= is_ext;
      warn_n      <= is_ext | ~warn_lat;
      shut_n      <= is_ext | ~shut_lat;
    end
  end

  AST_HOLD_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!drv_l_en && !drv_r_en && !mod_l_en && !mod_r_en)); // R1

  AST_OC_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    oc_lat |=> (!drv_l_en && !drv_r_en)); // R9

  AST_SHUT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    shut_lat |=> (!drv_l_en && !drv_r_en)); // R12

endmodule

// File: tb/amp_guard_ctrl_test.sv
`timescale 1ns/1ps
module amp_guard_ctrl_test;

  localparam int S  = 256;
  localparam int D  = 418;
  localparam int MD = 123;

  // fields: [5] mono strap, [4] ext strap, [3] drive en, [2] right mod en, [1] right from left, [0] shared pin oe
  localparam logic [5:0] VEC [4] = '{6'b00_1100, 6'b10_1010, 6'b01_0101, 6'b11_0101};

  logic clk = 1'b0;
  logic rst_n = 1'b0, mute_n = 1'b0, mono_strap = 1'b0, ext_strap = 1'b0;
  logic oc_det = 1'b0, th_warn = 1'b0, th_shut = 1'b0, th_cool = 1'b0;
  logic mod_l = 1'b0, mod_r = 1'b0;
  logic mod_l_en, mod_r_en, drv_l_en, drv_r_en, drv_l_data, drv_r_data, r_src_left;
  logic share_a_out, share_b_out, share_b_oe, warn_n, shut_n;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  amp_guard_ctrl #(.STARTUP_CYC(S), .UNMUTE_DLY(D), .MUTE_DLY(MD)) uut (
    .clk(clk), .rst_n(rst_n), .mute_n(mute_n), .mono_strap(mono_strap), .ext_strap(ext_strap),
    .oc_det(oc_det), .th_warn(th_warn), .th_shut(th_shut), .th_cool(th_cool),
    .mod_l(mod_l), .mod_r(mod_r), .mod_l_en(mod_l_en), .mod_r_en(mod_r_en),
    .drv_l_en(drv_l_en), .drv_r_en(drv_r_en), .drv_l_data(drv_l_data), .drv_r_data(drv_r_data),
    .r_src_left(r_src_left), .share_a_out(share_a_out), .share_b_out(share_b_out),
    .share_b_oe(share_b_oe), .warn_n(warn_n), .shut_n(shut_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1", mod_l_en, 1'b0);    chk("R1", drv_l_en, 1'b0);
    chk("R1", drv_r_en, 1'b0);    chk("R1", share_a_out, 1'b1);
    chk("R1", warn_n, 1'b1);      chk("R1", shut_n, 1'b1);
    chk("R1", share_b_oe, 1'b0);  chk("R1", mod_r_en, 1'b0);

    for (int i = 0; i < 4; i++) begin
      logic [5:0] v;
      v = VEC[i];
      rst_n = 1'b0; mono_strap = v[5]; ext_strap = v[4]; mute_n = 1'b1; mod_l = 1'b0; mod_r = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(S + D + 10);
      chk("R5", drv_l_en, v[3]);
      chk("R5", drv_r_en, v[3]);
      chk("R6", mod_r_en, v[2]);
      chk("R6", r_src_left, v[1]);
      chk("R8", share_b_oe, v[0]);
      for (int p = 0; p < 2; p++) begin
        mod_l = p[0]; mod_r = ~p[0];
        tick(1);
        if (v[0]) begin
          chk("R8", share_a_out, mod_l);
          chk("R8", share_b_out, mod_r);
          chk("R8", drv_l_data, 1'b0);
        end else begin
          chk("R7", drv_l_data, mod_l);
          chk(v[1] ? "R6" : "R7", drv_r_data, v[1] ? mod_l : mod_r);
        end
      end
      if (v[0]) begin
        oc_det = 1'b1; th_shut = 1'b1; th_warn = 1'b1;
        tick(6);
        chk("R8", share_a_out, mod_l);
        chk("R8", shut_n, 1'b1);
        chk("R8", warn_n, 1'b1);
        oc_det = 1'b0; th_shut = 1'b0; th_warn = 1'b0;
      end
    end

    // start-up in stereo with mute held
    mono_strap = 1'b0; ext_strap = 1'b0; mute_n = 1'b0; rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R2", mod_l_en, 1'b1);
    chk("R2", drv_l_en, 1'b0);
    tick(S + 20);
    chk("R2", drv_l_en, 1'b0);

    // R3 soft-start restart and exact delay
    mute_n = 1'b1; tick(100);
    mute_n = 1'b0; tick(2);
    chk("R3", drv_l_en, 1'b0);
    mute_n = 1'b1; tick(D);
    chk("R3", drv_l_en, 1'b0);
    tick(1);
    chk("R3", drv_l_en, 1'b1);

    // R4 exact stop delay
    mute_n = 1'b0; tick(MD);
    chk("R4", drv_l_en, 1'b1);
    tick(1);
    chk("R4", drv_r_en, 1'b0);
    mute_n = 1'b1; tick(D + 3);
    chk("R3", drv_l_en, 1'b1);

    // R5 strap change after release ignored
    mono_strap = 1'b1; ext_strap = 1'b1; tick(4);
    chk("R5", r_src_left, 1'b0);
    chk("R5", share_b_oe, 1'b0);
    chk("R5", drv_l_en, 1'b1);
    mono_strap = 1'b0; ext_strap = 1'b0;

    // R9 overcurrent filter and latch
    oc_det = 1'b1; tick(1); oc_det = 1'b0; tick(5);
    chk("R9", share_a_out, 1'b1);
    chk("R9", drv_l_en, 1'b1);
    oc_det = 1'b1; tick(5);
    chk("R9", share_a_out, 1'b0);
    chk("R9", drv_l_en, 1'b0);
    mute_n = 1'b0; tick(2); mute_n = 1'b1; tick(D + 5);
    chk("R10", share_a_out, 1'b0);
    chk("R10", drv_l_en, 1'b0);
    oc_det = 1'b0; tick(3);
    chk("R9", share_a_out, 1'b0);
    mute_n = 1'b0; tick(2); mute_n = 1'b1; tick(2);
    chk("R10", share_a_out, 1'b1);
    tick(D + 3);
    chk("R10", drv_l_en, 1'b1);

    // R11 warning with hysteresis
    th_warn = 1'b1; tick(5);
    chk("R11", warn_n, 1'b0);
    chk("R11", drv_l_en, 1'b1);
    th_warn = 1'b0; tick(5);
    chk("R11", warn_n, 1'b0);
    th_cool = 1'b1; tick(5);
    chk("R11", warn_n, 1'b1);
    th_cool = 1'b0;

    // R12 shutdown and automatic recovery
    th_shut = 1'b1; th_warn = 1'b1; tick(6);
    chk("R12", shut_n, 1'b0);
    chk("R12", drv_l_en, 1'b0);
    th_shut = 1'b0; th_warn = 1'b0; tick(4);
    chk("R12", shut_n, 1'b0);
    th_cool = 1'b1; tick(5);
    chk("R12", shut_n, 1'b1);
    chk("R12", warn_n, 1'b1);
    chk("R12", drv_l_en, 1'b0);
    th_cool = 1'b0; tick(D + 3);
    chk("R12", drv_l_en, 1'b1);

    // reset pulse clears a latched overcurrent
    oc_det = 1'b1; tick(4);
    chk("R9", share_a_out, 1'b0);
    oc_det = 1'b0; rst_n = 1'b0; tick(1);
    chk("R1", drv_l_en, 1'b0);
    chk("R1", mod_l_en, 1'b0);
    tick(1);
    rst_n = 1'b1; tick(2);
    chk("R10", share_a_out, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule